// File: doc/BRIEF.md
# Serial Programming Host Sequencer for Paired Flash Word Writes

This block sits on the host side of a two-wire in-circuit serial programming link: one serial clock and one bidirectional data line. It writes pairs of 24-bit instruction words into a target's executive flash. The block does not shift raw data. It builds the instructions that the target executes and sends them as frames. Each frame is a 4-bit command followed by either a 24-bit instruction to execute or a 16-bit status word clocked back from the target's readback register.

After a start pulse, the block sends the reset-exit sequence and sets the table page. It then loops over the input stream. For each pair it pops three packed 16-bit words from a show-ahead FIFO interface and turns them into move-immediate instructions. It then loads the target's write latches, points the target at the destination row, arms the control register and sends the two-key unlock followed by the bit-set that starts the write. It polls the target's busy bit until the write completes. The destination address advances by 4 per pair. The run ends with a one-cycle done pulse once the pair holding the stream's last word is programmed, or with a sticky error flag if a write never completes.

Bit timing comes from a divider: each bit is `CLK_DIV` system clocks with the serial clock low, then `CLK_DIV` with it high.

Top module: `host_isp_seq`

## Requirements
- R1: After reset, ser_clk is 0, ser_dout is 0, ser_oe is 1, and busy, done, error and in_pop are all 0.
- R2: Every frame starts with a 4-bit command, followed by its payload. All bits are sent least-significant bit first. Each bit holds ser_clk low for CLK_DIV cycles and then high for CLK_DIV cycles. ser_dout changes only while ser_clk is low, and the target samples it on the rising edge. Command 0000 is followed by a 24-bit instruction. Command 0001 is followed by 16 readback bits.
- R3: After start, the instructions sent are 000000 three times, then 040200, then 000000 three times, then 200FAC, then 8802AC.
- R4: For each pair, the block pops three words A, B, C from the input, with in_pop only while in_valid is high. It then sends the move-immediates 2AAAA0, 2BBBB1 and 2CCCC2. A move-immediate is the nibble 2, then the 16-bit literal, then the 4-bit destination register number.
- R5: The latch load follows, in this order: EB0300, NOP, EB0380, NOP, BB0BB6, NOP, NOP, BBDBB6, NOP, NOP, BBEBB6, NOP, NOP, BB0B96, NOP, NOP. Here NOP is 000000.
- R6: The row address frames come next: a move-immediate of address bits 15:0 to register 3, a move-immediate of {8'h00, address bits 23:16} to register 4, then 884693 and 8846A4.
- R7: The write is started with 24001A, NOP, 88468A, NOP, NOP, 200551, 8846B1, 200AA1, 8846B1, A8F1A1, and then five NOPs.
- R8: Each poll is NOP, 804680, NOP, 887E60, NOP, then one command-0001 frame, then NOP three times, 040200, and NOP three times. During the 16 readback bits ser_oe is 0; at all other times it is 1. The poll repeats while bit 15 of the readback word (its last bit) is 1.
- R9: If bit 15 still reads 1 after MAX_POLLS polls of one pair, error goes to 1, busy goes to 0 and no further frame is sent. error stays 1 until the next accepted start.
- R10: When a poll reads bit 15 as 0, the address is increased by 4, wrapping at 24 bits. Unless the run has ended, the next pair is fetched.
- R11: Once the pair containing a word popped with in_last is complete, done is high for exactly one cycle, busy falls in that same cycle, and error stays 0.
- R12: A start pulse while busy is 1 has no effect on the frames sent or on the address used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request to begin a programming run |
| dest_addr | input | 24 | First destination row address, captured at start |
| in_data | input | 16 | Head word of the packed input stream |
| in_valid | input | 1 | Head word is present |
| in_last | input | 1 | Head word is the final word of the stream |
| in_pop | output | 1 | Consume the head word this cycle |
| ser_clk | output | 1 | Serial clock to the target |
| ser_dout | output | 1 | Serial data driven to the target |
| ser_oe | output | 1 | 1 while the host drives the data line, 0 while the target drives it |
| ser_din | input | 1 | Serial data read back from the target |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the successful end of a run |
| error | output | 1 | Sticky flag: a write never reported completion |

## Verification
Several properties are checked on every cycle. The serial clock rests low when idle, and data never moves while the serial clock is high. The line is released only during a run, and FIFO pops never outrun in_valid. done is a single cycle that coincides with idle and excludes error, and error holds until a new start. The bench's scenarios are needed for the ordered content of each frame: the move-immediate literals taken from the stream, the address progression including carry into the upper byte, and the number of polls as a function of the target's busy replies. They are also needed for the timeout cut-off and for a start that arrives while a run is in progress. A frame-decoding target model checks each of these against a frame list built independently.

// File: rtl/host_isp_pkg.sv
package host_isp_pkg;

  localparam int STEP_W = 6;

  typedef enum logic [1:0] {
    SEG_INIT = 2'd0,
    SEG_PAIR = 2'd1,
    SEG_POLL = 2'd2
  } seg_e;

  localparam logic [3:0] CMD_EXEC = 4'b0000;
  localparam logic [3:0] CMD_READ = 4'b0001;

  localparam logic [23:0] OP_NOP       = 24'h000000;
  localparam logic [23:0] OP_JUMP      = 24'h040200;
  localparam logic [23:0] OP_PAGE_LIT  = 24'h200FAC;
  localparam logic [23:0] OP_PAGE_SET  = 24'h8802AC;
  localparam logic [23:0] OP_CLR_RD    = 24'hEB0300;
  localparam logic [23:0] OP_CLR_WR    = 24'hEB0380;
  localparam logic [23:0] OP_LATCH_LO0 = 24'hBB0BB6;
  localparam logic [23:0] OP_LATCH_HI0 = 24'hBBDBB6;
  localparam logic [23:0] OP_LATCH_HI1 = 24'hBBEBB6;
  localparam logic [23:0] OP_LATCH_LO1 = 24'hBB0B96;
  localparam logic [23:0] OP_ADR_LO    = 24'h884693;
  localparam logic [23:0] OP_ADR_HI    = 24'h8846A4;
  localparam logic [23:0] OP_CTL_LIT   = 24'h24001A;
  localparam logic [23:0] OP_CTL_SET   = 24'h88468A;
  localparam logic [23:0] OP_KEY1_LIT  = 24'h200551;
  localparam logic [23:0] OP_KEY_SET   = 24'h8846B1;
  localparam logic [23:0] OP_KEY2_LIT  = 24'h200AA1;
  localparam logic [23:0] OP_FIRE      = 24'hA8F1A1;
  localparam logic [23:0] OP_CTL_GET   = 24'h804680;
  localparam logic [23:0] OP_VIS_SET   = 24'h887E60;

  localparam logic [STEP_W-1:0] INIT_LAST = STEP_W'(8);
  localparam logic [STEP_W-1:0] PAIR_LAST = STEP_W'(37);
  localparam logic [STEP_W-1:0] POLL_LAST = STEP_W'(12);
  localparam logic [STEP_W-1:0] POLL_READ = STEP_W'(5);

  function automatic logic [23:0] mov_imm(input logic [15:0] lit, input logic [3:0] rd);
    return {4'h2, lit, rd};
  endfunction

endpackage

// File: rtl/host_isp_frame_rom.sv
module host_isp_frame_rom
  import host_isp_pkg::*;
(
  input  seg_e                seg,
  input  logic [STEP_W-1:0]   step,
  input  logic [2:0][15:0]    words,
  input  logic [23:0]         addr,
  output logic                is_read,
  output logic [23:0]         insn
);

  logic [23:0] init_op;
  logic [23:0] pair_op;
  logic [23:0] poll_op;

  always_comb begin
    case (step)
      STEP_W'(3): init_op = OP_JUMP;
      STEP_W'(7): init_op = OP_PAGE_LIT;
      STEP_W'(8): init_op = OP_PAGE_SET;
      default:    init_op = OP_NOP;
    endcase
  end

  always_comb begin
    case (step)
      STEP_W'(0):  pair_op = mov_imm(words[0], 4'd0);
      STEP_W'(1):  pair_op = mov_imm(words[1], 4'd1);
      STEP_W'(2):  pair_op = mov_imm(words[2], 4'd2);
      STEP_W'(3):  pair_op = OP_CLR_RD;
      STEP_W'(5):  pair_op = OP_CLR_WR;
      STEP_W'(7):  pair_op = OP_LATCH_LO0;
      STEP_W'(10): pair_op = OP_LATCH_HI0;
      STEP_W'(13): pair_op = OP_LATCH_HI1;
      STEP_W'(16): pair_op = OP_LATCH_LO1;
      STEP_W'(19): pair_op = mov_imm(addr[15:0], 4'd3);
      STEP_W'(20): pair_op = mov_imm({8'h00, addr[23:16]}, 4'd4);
      STEP_W'(21): pair_op = OP_ADR_LO;
      STEP_W'(22): pair_op = OP_ADR_HI;
      STEP_W'(23): pair_op = OP_CTL_LIT;
      STEP_W'(25): pair_op = OP_CTL_SET;
      STEP_W'(28): pair_op = OP_KEY1_LIT;
      STEP_W'(29): pair_op = OP_KEY_SET;
      STEP_W'(30): pair_op = OP_KEY2_LIT;
      STEP_W'(31): pair_op = OP_KEY_SET;
      STEP_W'(32): pair_op = OP_FIRE;
      default:     pair_op = OP_NOP;
    endcase
  end

  always_comb begin
    case (step)
      STEP_W'(1): poll_op = OP_CTL_GET;
      STEP_W'(3): poll_op = OP_VIS_SET;
      STEP_W'(9): poll_op = OP_JUMP;
      default:    poll_op = OP_NOP;
    endcase
  end

  always_comb begin
    is_read = 1'b0;
    case (seg)
      SEG_INIT: insn = init_op;
      SEG_PAIR: insn = pair_op;
      SEG_POLL: begin
        insn    = poll_op;
        is_read = (step == POLL_READ);
      end
      default:  insn = OP_NOP;
    endcase
  end

endmodule

// File: rtl/host_isp_bit_shifter.sv
module host_isp_bit_shifter
  import host_isp_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        is_read,
  input  logic [23:0] insn,
  input  logic        ser_din,
  output logic        ser_clk,
  output logic        ser_dout,
  output logic        ser_oe,
  output logic        idle,
  output logic        frame_done,
  output logic        rx_last
);

  localparam int DIV_W     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CMD_BITS  = 4;
  localparam int EXEC_BITS = CMD_BITS + 24;
  localparam int READ_BITS = CMD_BITS + 16;
  localparam int BIT_W     = $clog2(EXEC_BITS);
  localparam int SR_W      = EXEC_BITS;

  localparam logic [DIV_W-1:0] DIV_END   = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] EXEC_END  = BIT_W'(EXEC_BITS - 1);
  localparam logic [BIT_W-1:0] READ_END  = BIT_W'(READ_BITS - 1);
  localparam logic [BIT_W-1:0] CMD_BITSW = BIT_W'(CMD_BITS);

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_e;

  sh_e              st_q, st_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [SR_W-1:0]  sr_q, sr_n;
  logic             rd_q, rd_n;
  logic             rx_q, rx_n;
  logic             in_rx;
  logic [BIT_W-1:0] bit_end;

  assign in_rx   = rd_q && (bit_q >= CMD_BITSW);
  assign bit_end = rd_q ? READ_END : EXEC_END;

  always_comb begin
    st_n       = st_q;
    div_n      = div_q;
    bit_n      = bit_q;
    sr_n       = sr_q;
    rd_n       = rd_q;
    rx_n       = rx_q;
    frame_done = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (go) begin
          sr_n  = {insn, (is_read ? CMD_READ : CMD_EXEC)};
          rd_n  = is_read;
          bit_n = '0;
          div_n = '0;
          st_n  = SH_LOW;
        end
      end
      SH_LOW: begin
        if (div_q == DIV_END) begin
          div_n = '0;
          st_n  = SH_HIGH;
          if (in_rx) rx_n = ser_din;
        end else begin
          div_n = div_q + 1'b1;
        end
      end
      SH_HIGH: begin
        if (div_q == DIV_END) begin
          div_n = '0;
          sr_n  = {1'b0, sr_q[SR_W-1:1]};
          if (bit_q == bit_end) begin
            st_n       = SH_IDLE;
            frame_done = 1'b1;
          end else begin
            st_n  = SH_LOW;
            bit_n = bit_q + 1'b1;
          end
        end else begin
          div_n = div_q + 1'b1;
        end
      end
      default: st_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      div_q <= '0;
      bit_q <= '0;
      sr_q  <= '0;
      rd_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      div_q <= div_n;
      bit_q <= bit_n;
      sr_q  <= sr_n;
      rd_q  <= rd_n;
      rx_q  <= rx_n;
    end
  end

  assign idle     = (st_q == SH_IDLE);
  assign ser_clk  = (st_q == SH_HIGH);
  assign ser_dout = !idle && !in_rx && sr_q[0];
  assign ser_oe   = idle || !in_rx;
  assign rx_last  = rx_q;

endmodule

// File: rtl/host_isp_seq_ctrl.sv
module host_isp_seq_ctrl
  import host_isp_pkg::*;
#(
  parameter int MAX_POLLS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [23:0]         dest_addr,
  input  logic [15:0]         in_data,
  input  logic                in_valid,
  input  logic                in_last,
  output logic                in_pop,
  input  logic                sh_idle,
  input  logic                frame_done,
  input  logic                rx_last,
  output logic                go,
  output seg_e                seg,
  output logic [STEP_W-1:0]   step,
  output logic [2:0][15:0]    words,
  output logic [23:0]         addr,
  output logic                busy,
  output logic                done,
  output logic                error
);

  localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [POLL_W-1:0] POLL_END = POLL_W'(MAX_POLLS - 1);

  typedef enum logic [2:0] {C_IDLE, C_INIT, C_FETCH, C_PAIR, C_POLL} ctl_e;

  ctl_e              st_q, st_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              iss_q, iss_n;
  logic [2:0][15:0]  wd_q, wd_n;
  logic [1:0]        fetch_q, fetch_n;
  logic              last_q, last_n;
  logic [23:0]       addr_q, addr_n;
  logic [POLL_W-1:0] poll_q, poll_n;
  logic              pbusy_q, pbusy_n;
  logic              err_q, err_n;
  logic              done_q, done_n;
  logic              emitting;

  assign emitting = (st_q == C_INIT) || (st_q == C_PAIR) || (st_q == C_POLL);
  assign go       = emitting && sh_idle && !iss_q;
  assign in_pop   = (st_q == C_FETCH) && in_valid;

  always_comb begin
    case (st_q)
      C_INIT:  seg = SEG_INIT;
      C_POLL:  seg = SEG_POLL;
      default: seg = SEG_PAIR;
    endcase
  end

  always_comb begin
    st_n    = st_q;
    step_n  = step_q;
    iss_n   = iss_q;
    wd_n    = wd_q;
    fetch_n = fetch_q;
    last_n  = last_q;
    addr_n  = addr_q;
    poll_n  = poll_q;
    pbusy_n = pbusy_q;
    err_n   = err_q;
    done_n  = 1'b0;

    if (go)         iss_n = 1'b1;
    if (frame_done) iss_n = 1'b0;

    case (st_q)
      C_IDLE: begin
        if (start) begin
          st_n   = C_INIT;
          step_n = '0;
          iss_n  = 1'b0;
          addr_n = dest_addr;
          err_n  = 1'b0;
          last_n = 1'b0;
        end
      end
      C_INIT: begin
        if (frame_done) begin
          if (step_q == INIT_LAST) begin
            st_n    = C_FETCH;
            step_n  = '0;
            fetch_n = '0;
          end else begin
            step_n = step_q + 1'b1;
          end
        end
      end
      C_FETCH: begin
        if (in_valid) begin
          for (int k = 0; k < 3; k++) begin
            if (fetch_q == 2'(k)) wd_n[k] = in_data;
          end
          last_n = last_q || in_last;
          if (fetch_q == 2'd2) begin
            st_n    = C_PAIR;
            step_n  = '0;
            fetch_n = '0;
          end else begin
            fetch_n = fetch_q + 1'b1;
          end
        end
      end
      C_PAIR: begin
        if (frame_done) begin
          if (step_q == PAIR_LAST) begin
            st_n   = C_POLL;
            step_n = '0;
            poll_n = '0;
          end else begin
            step_n = step_q + 1'b1;
          end
        end
      end
      C_POLL: begin
        if (frame_done) begin
          if (step_q == POLL_READ) pbusy_n = rx_last;
          if (step_q == POLL_LAST) begin
            step_n = '0;
            if (pbusy_q) begin
              if (poll_q == POLL_END) begin
                err_n = 1'b1;
                st_n  = C_IDLE;
              end else begin
                poll_n = poll_q + 1'b1;
              end
            end else begin
              addr_n = addr_q + 24'd4;
              if (last_q) begin
                done_n = 1'b1;
                st_n   = C_IDLE;
              end else begin
                st_n    = C_FETCH;
                fetch_n = '0;
              end
            end
          end else begin
            step_n = step_q + 1'b1;
          end
        end
      end
      default: st_n = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      step_q  <= '0;
      iss_q   <= 1'b0;
      wd_q    <= '0;
      fetch_q <= '0;
      last_q  <= 1'b0;
      addr_q  <= '0;
      poll_q  <= '0;
      pbusy_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      step_q  <= step_n;
      iss_q   <= iss_n;
      wd_q    <= wd_n;
      fetch_q <= fetch_n;
      last_q  <= last_n;
      addr_q  <= addr_n;
      poll_q  <= poll_n;
      pbusy_q <= pbusy_n;
      err_q   <= err_n;
      done_q  <= done_n;
    end
  end

  assign step  = step_q;
  assign words = wd_q;
  assign addr  = addr_q;
  assign busy  = (st_q != C_IDLE);
  assign done  = done_q;
  assign error = err_q;

endmodule

// File: rtl/host_isp_seq.sv
module host_isp_seq
  import host_isp_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int MAX_POLLS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] dest_addr,
  input  logic [15:0] in_data,
  input  logic        in_valid,
  input  logic        in_last,
  output logic        in_pop,
  output logic        ser_clk,
  output logic        ser_dout,
  output logic        ser_oe,
  input  logic        ser_din,
  output logic        busy,
  output logic        done,
  output logic        error
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic              sh_go;
  logic              sh_idle;
  logic              sh_done;
  logic              sh_rx;
  logic              fr_read;
  logic [23:0]       fr_insn;
  seg_e              cur_seg;
  logic [STEP_W-1:0] cur_step;
  logic [2:0][15:0]  cur_words;
  logic [23:0]       cur_addr;

  host_isp_seq_ctrl #(.MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .dest_addr  (dest_addr),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_pop     (in_pop),
    .sh_idle    (sh_idle),
    .frame_done (sh_done),
    .rx_last    (sh_rx),
    .go         (sh_go),
    .seg        (cur_seg),
    .step       (cur_step),
    .words      (cur_words),
    .addr       (cur_addr),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  host_isp_frame_rom u_rom (
    .seg     (cur_seg),
    .step    (cur_step),
    .words   (cur_words),
    .addr    (cur_addr),
    .is_read (fr_read),
    .insn    (fr_insn)
  );

  host_isp_bit_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (sh_go),
    .is_read    (fr_read),
    .insn       (fr_insn),
    .ser_din    (ser_din),
    .ser_clk    (ser_clk),
    .ser_dout   (ser_dout),
    .ser_oe     (ser_oe),
    .idle       (sh_idle),
    .frame_done (sh_done),
    .rx_last    (sh_rx)
  );

endmodule

// File: rtl/host_isp_seq_chk.sv
module host_isp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic error,
  input logic in_pop,
  input logic in_valid,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_oe
);

  AST_IDLE_CLK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ser_clk);                 // R2
  AST_DOUT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ser_dout) |-> !ser_clk);   // R2
  AST_RELEASE_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) !ser_oe |-> busy);                   // R8
  AST_POP_VALID:     assert property (@(posedge clk) disable iff (!rst_n) in_pop |-> in_valid);                // R4
  AST_POP_BUSY:      assert property (@(posedge clk) disable iff (!rst_n) in_pop |-> busy);                    // R4
  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                     // R11
  AST_DONE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !error));         // R11
  AST_ERR_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (error && !start) |=> error);        // R9
  AST_ERR_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) error |-> !busy);                    // R9

endmodule

bind host_isp_seq host_isp_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .in_pop   (in_pop),
  .in_valid (in_valid),
  .ser_clk  (ser_clk),
  .ser_dout (ser_dout),
  .ser_oe   (ser_oe)
);

// File: tb/tb_host_isp_seq.sv
`timescale 1ns/1ps
module tb_host_isp_seq;

  localparam int DIV   = 1;
  localparam int MAXP  = 3;
  localparam int EXP_N = 1024;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] dest_addr;
  logic [15:0] in_data;
  logic        in_valid;
  logic        in_last;
  logic        in_pop;
  logic        ser_clk;
  logic        ser_dout;
  logic        ser_oe;
  logic        ser_din;
  logic        busy;
  logic        done;
  logic        error;

  host_isp_seq #(.CLK_DIV(DIV), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dest_addr(dest_addr),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_pop(in_pop),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_oe(ser_oe), .ser_din(ser_din),
    .busy(busy), .done(done), .error(error)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- input stream model ----------------
  logic [15:0] fw [0:63];
  int          fcount = 0;
  int          fidx   = 0;
  bit          gate   = 1'b1;
  bit          gaps   = 1'b0;

  assign in_valid = (fidx < fcount) && gate;
  assign in_data  = (fidx < fcount) ? fw[fidx] : 16'h0;
  assign in_last  = (fidx == fcount - 1);

  always @(posedge clk) if (in_pop) fidx <= fidx + 1;
  always @(negedge clk) gate <= gaps ? ($urandom_range(0, 3) != 0) : 1'b1;

  // ---------------- target model / frame decoder ----------------
  int          busy_n [0:15];
  int          tpair  = 0;
  int          treads = 0;
  int          mbc    = 0;
  logic [3:0]  mcmd;
  logic [23:0] mpay;
  logic [15:0] resp;
  int          got_n  = 0;
  bit          got_rd  [0:EXP_N-1];
  logic [23:0] got_pay [0:EXP_N-1];
  int          oe_bad = 0;

  always @(posedge ser_clk) begin
    if (mbc < 4) begin
      mcmd[mbc] = ser_dout;
      if (!ser_oe) oe_bad++;
    end else if (mcmd == 4'b0000) begin
      mpay[mbc-4] = ser_dout;
      if (!ser_oe) oe_bad++;
    end else begin
      if (ser_oe) oe_bad++;
    end
    mbc++;
    if (mbc == 4) begin
      mpay = '0;
      if (mcmd == 4'b0001) begin
        resp[14:0] = 15'($urandom);
        resp[15]   = (treads < busy_n[tpair]);
        if (resp[15]) treads++;
        else begin tpair++; treads = 0; end
      end
    end
    if ((mcmd == 4'b0000 && mbc == 28) || (mcmd != 4'b0000 && mbc == 20)) begin
      if (got_n < EXP_N) begin
        got_rd[got_n]  = (mcmd == 4'b0001);
        got_pay[got_n] = (mcmd == 4'b0001) ? 24'h0 : mpay;
      end
      got_n++;
      mbc = 0;
    end
  end

  always @(negedge ser_clk) begin
    if (mbc >= 4 && mbc < 20 && mcmd == 4'b0001) ser_din = resp[mbc-4];
  end

  // serial clock high phase length
  int hi_run = 0;
  int phase_bad = 0;
  int done_cnt = 0;
  always @(negedge clk) begin
    if (ser_clk) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != DIV) phase_bad++;
      hi_run = 0;
    end
    if (done) done_cnt++;
  end

  // ---------------- expected frame list ----------------
  bit          exp_rd  [0:EXP_N-1];
  logic [23:0] exp_pay [0:EXP_N-1];
  string       exp_tag [0:EXP_N-1];
  int          exp_n;
  bit          exp_err;

  function automatic logic [23:0] movi(input logic [15:0] lit, input logic [3:0] r);
    return {4'h2, lit, r};
  endfunction

  task automatic push(input logic [23:0] op, input string tag);
    exp_rd[exp_n] = 1'b0; exp_pay[exp_n] = op; exp_tag[exp_n] = tag; exp_n++;
  endtask

  task automatic push_nops(input int n, input string tag);
    for (int i = 0; i < n; i++) push(24'h000000, tag);
  endtask

  task automatic build_expected(input logic [23:0] a0, input int npairs);
    logic [23:0] a;
    int np;
    exp_n = 0; exp_err = 0; a = a0;
    push_nops(3, "R3"); push(24'h040200, "R3"); push_nops(3, "R3");
    push(24'h200FAC, "R3"); push(24'h8802AC, "R3");
    for (int p = 0; p < npairs && !exp_err; p++) begin
      push(movi(fw[3*p],   4'd0), "R4");
      push(movi(fw[3*p+1], 4'd1), "R4");
      push(movi(fw[3*p+2], 4'd2), "R4");
      push(24'hEB0300, "R5"); push_nops(1, "R5");
      push(24'hEB0380, "R5"); push_nops(1, "R5");
      push(24'hBB0BB6, "R5"); push_nops(2, "R5");
      push(24'hBBDBB6, "R5"); push_nops(2, "R5");
      push(24'hBBEBB6, "R5"); push_nops(2, "R5");
      push(24'hBB0B96, "R5"); push_nops(2, "R5");
      push(movi(a[15:0], 4'd3), "R6");
      push(movi({8'h00, a[23:16]}, 4'd4), "R6");
      push(24'h884693, "R6"); push(24'h8846A4, "R6");
      push(24'h24001A, "R7"); push_nops(1, "R7"); push(24'h88468A, "R7"); push_nops(2, "R7");
      push(24'h200551, "R7"); push(24'h8846B1, "R7"); push(24'h200AA1, "R7");
      push(24'h8846B1, "R7"); push(24'hA8F1A1, "R7"); push_nops(5, "R7");
      np = (busy_n[p] >= MAXP) ? MAXP : busy_n[p] + 1;
      for (int q = 0; q < np; q++) begin
        push_nops(1, "R8"); push(24'h804680, "R8"); push_nops(1, "R8");
        push(24'h887E60, "R8"); push_nops(1, "R8");
        exp_rd[exp_n] = 1'b1; exp_pay[exp_n] = 24'h0; exp_tag[exp_n] = "R8"; exp_n++;
        push_nops(3, "R8"); push(24'h040200, "R8"); push_nops(3, "R8");
      end
      if (busy_n[p] >= MAXP) exp_err = 1;
      a = a + 24'd4;
    end
  endtask

  // ---------------- run one job ----------------
  task automatic run_job(input logic [23:0] a0, input int npairs, input bit restart_mid,
                         input string label);
    int d0;
    fcount = 3 * npairs; fidx = 0; tpair = 0; treads = 0;
    got_n = 0; mbc = 0; oe_bad = 0; phase_bad = 0;
    build_expected(a0, npairs);
    d0 = done_cnt;
    @(negedge clk); dest_addr = a0; start = 1'b1;
    @(negedge clk); start = 1'b0; dest_addr = ~a0;
    chk(busy == 1'b1, "R3 busy after start", 32'(busy), 1);
    chk(error == 1'b0, "R9 error cleared by start", 32'(error), 0);
    if (restart_mid) begin
      repeat (700) @(negedge clk);
      dest_addr = 24'h123450; start = 1'b1;   // R12: start while busy
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(got_n == exp_n, {label, " R2 frame count"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_rd[i] == exp_rd[i] && got_pay[i] == exp_pay[i],
          {label, " ", exp_tag[i], " frame"}, {7'b0, got_rd[i], got_pay[i]}, {7'b0, exp_rd[i], exp_pay[i]});
    chk(oe_bad == 0, {label, " R8 line direction"}, 32'(oe_bad), 0);
    chk(phase_bad == 0, {label, " R2 high phase length"}, 32'(phase_bad), 0);
    chk(error == exp_err, {label, " R9 error flag"}, 32'(error), 32'(exp_err));
    chk(done_cnt - d0 == (exp_err ? 0 : 1), {label, " R11 done pulses"}, 32'(done_cnt - d0), exp_err ? 0 : 1);
    if (!exp_err)
      chk(fidx == fcount, {label, " R10 all words popped"}, 32'(fidx), 32'(fcount));
    if (restart_mid)
      chk(got_n == exp_n, {label, " R12 restart ignored"}, 32'(got_n), 32'(exp_n));
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0; start = 1'b0; dest_addr = '0; ser_din = 1'b0;
    for (int i = 0; i < 16; i++) busy_n[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_clk == 0 && ser_dout == 0 && ser_oe == 1, "R1 serial reset state",
        {29'b0, ser_clk, ser_dout, ser_oe}, 32'b001);
    chk(busy == 0 && done == 0 && error == 0 && in_pop == 0, "R1 control reset state",
        {28'b0, busy, done, error, in_pop}, 0);

    // directed: address carry into upper byte, second pair busy twice
    fw[0] = 16'hA5C3; fw[1] = 16'h12EF; fw[2] = 16'h0001;
    fw[3] = 16'hFFFF; fw[4] = 16'h8000; fw[5] = 16'h7E81;
    busy_n[0] = 0; busy_n[1] = 2;
    run_job(24'h00FFFC, 2, 1'b0, "T1");

    // random data with stream gaps and a start while busy
    gaps = 1'b1;
    for (int i = 0; i < 9; i++) fw[i] = 16'($urandom);
    for (int i = 0; i < 3; i++) busy_n[i] = $urandom_range(0, 2);
    run_job({$urandom_range(0, 24'h3FFFFF), 2'b00}, 3, 1'b1, "T2");

    // timeout on the first pair
    gaps = 1'b0;
    for (int i = 0; i < 6; i++) fw[i] = 16'($urandom);
    busy_n[0] = 50;
    run_job(24'h000200, 2, 1'b0, "T3");
    begin
      int g;
      g = got_n;
      repeat (300) @(negedge clk);
      chk(got_n == g, "R9 no frames after timeout", 32'(got_n), 32'(g));
      chk(error == 1 && busy == 0, "R9 error holds while idle", {30'b0, error, busy}, 32'b10);
    end

    // recovery with top-of-space wrap
    for (int i = 0; i < 3; i++) fw[i] = 16'($urandom);
    busy_n[0] = MAXP - 1;
    run_job(24'hFFFFFC, 1, 1'b0, "T4");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule